// File: doc/BRIEF.md
# Cascaded Noise-Shaping Duty Truncator

This block sits between a digital control loop and a coarse PWM core. It receives an 11-bit duty-cycle word once per switching period and reduces it to a 6-bit word. The bits that are dropped are not simply discarded. They are carried forward by two cascaded first-order error-feedback loops. The result is that the truncation error in the output sequence is pushed toward high frequencies with second-order shaping. Each loop, taken alone, is only first order, so the structure stays stable for any input.

The first loop adds its stored remainder to the input word. It sends the bits above bit 6 onward as a coarse value and keeps the low 7 bits as its remainder. The second loop takes that fresh 7-bit remainder as its input. It adds its own stored 5-bit remainder, sends the bits above bit 4 onward and keeps the low 5 bits. The coarse value is then scaled by 4. The first difference of the second loop's value is added to it. The sum is clamped to the 6-bit range and registered as the output duty word. All state moves only when the per-period strobe is high.

Top module: `mash11_duty_truncator`

## Requirements
- R1: While reset (active low) is held, `duty_out` reads 0 and `duty_vld` reads 0. Reset also clears both remainders and the stored previous second-loop value, so the first period after reset behaves as if all three are zero.
- R2: First loop: sum1 = duty_in + rem1. The coarse value c1 = sum1 >> 7, and the new rem1 = sum1 mod 128.
- R3: Second loop: sum2 = new rem1 + rem2. The value c2 = sum2 >> 5, and the new rem2 = sum2 mod 32.
- R4: The unclamped result is 4·c1 + c2 − c2_prev. Here c2_prev is the c2 of the previous strobed period, or 0 after reset.
- R5: The result is clamped to 0 when it is negative and to 63 when it is above 63 before it is registered into `duty_out`.
- R6: Without a strobe, no state changes and `duty_in` is ignored: `duty_out` holds its value, and the next strobed result is the same as if `duty_in` had never changed.
- R7: `duty_vld` is high for exactly the one clock that follows each clock with `upd` high. `duty_out` takes its new value at that same edge.
- R8: For a constant input between 256 and 1791, the sum of 128 consecutive outputs multiplied by 32 is within 128 of 128 × duty_in. This means the mean output scaled by 32 matches the input within one input LSB.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| upd | input | 1 | One-clock strobe, once per switching period |
| duty_in | input | 11 | High-resolution duty word |
| duty_out | output | 6 | Noise-shaped reduced duty word |
| duty_vld | output | 1 | High for one clock after each strobe |

## Verification
The bench sweeps constant inputs across the whole 11-bit range in steps of 13, holding each value for 128 periods. It compares every strobed output with an arithmetic model of the two loops. It also checks that the long-run mean tracks the input in the mid range.

- Inputs at 0, at full scale and near the bottom are the cases that drive the clamp.
- Between strobes the bench drives a changed `duty_in`. This shows whether the state leaks without a strobe.
- A known three-period sequence after a mid-run reset separates correctly cleared remainders from stale ones.

// File: rtl/mash11_duty_truncator.sv
module mash11_duty_truncator #(
  parameter int IN_W    = 11,
  parameter int S1_KEEP = 7,
  parameter int S2_KEEP = 5,
  parameter int OUT_W   = IN_W - S2_KEEP
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd,
  input  logic [IN_W-1:0]  duty_in,
  output logic [OUT_W-1:0] duty_out,
  output logic             duty_vld
);
  localparam int S1_W = IN_W + 1;
  localparam int C1_W = S1_W - S1_KEEP;
  localparam int S2_W = S1_KEEP + 1;
  localparam int C2_W = S2_W - S2_KEEP;
  localparam int GAP  = S1_KEEP - S2_KEEP;
  localparam int V_W  = OUT_W + 3;
  localparam int OMAX = (1 << OUT_W) - 1;

  logic [S1_KEEP-1:0] rem1_q;
  logic [S2_KEEP-1:0] rem2_q;
  logic [C2_W-1:0]    c2_q;

  wire [S1_W-1:0]    sum1   = {1'b0, duty_in} + S1_W'(rem1_q);
  wire [C1_W-1:0]    c1     = sum1[S1_W-1:S1_KEEP];
  wire [S1_KEEP-1:0] rem1_d = sum1[S1_KEEP-1:0];
  wire [S2_W-1:0]    sum2   = {1'b0, rem1_d} + S2_W'(rem2_q);
  wire [C2_W-1:0]    c2     = sum2[S2_W-1:S2_KEEP];
  wire [S2_KEEP-1:0] rem2_d = sum2[S2_KEEP-1:0];

  wire signed [V_W-1:0] mix =
    $signed((V_W'(c1) << GAP) + V_W'(c2) - V_W'(c2_q));

  logic [OUT_W-1:0] clamped;
  always_comb begin
    if (mix < 0)
      clamped = '0;
    else if (mix > $signed(V_W'(OMAX)))
      clamped = OUT_W'(OMAX);
    else
      clamped = mix[OUT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rem1_q   <= '0;
      rem2_q   <= '0;
      c2_q     <= '0;
      duty_out <= '0;
      duty_vld <= 1'b0;
    end else begin
      duty_vld <= upd;
      if (upd) begin
        rem1_q   <= rem1_d;
        rem2_q   <= rem2_d;
        c2_q     <= c2;
        duty_out <= clamped;
      end
    end
  end

  assert_vld_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
    upd |=> duty_vld);
  assert_vld_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |=> !duty_vld);
  assert_hold_out_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |=> $stable(duty_out));
  assert_hold_state_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |=> ($stable(rem1_q) && $stable(rem2_q) && $stable(c2_q)));
  assert_c2_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    c2_q <= C2_W'(1 << GAP));
endmodule

// File: tb/sim_mash11_duty_truncator.sv
module sim_mash11_duty_truncator;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic upd = 1'b0;
  logic [10:0] duty_in = '0;
  logic [5:0] duty_out;
  logic duty_vld;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  int m_r1 = 0, m_r2 = 0, m_c2p = 0;

  always #2 clk = ~clk;

  mash11_duty_truncator u0 (
    .clk(clk), .rst_n(rst_n), .upd(upd),
    .duty_in(duty_in), .duty_out(duty_out), .duty_vld(duty_vld)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int model_step(input int u);
    int s1, c1, s2, c2, v;
    s1 = u + m_r1;
    c1 = s1 / 128;
    m_r1 = s1 % 128;
    s2 = m_r1 + m_r2;
    c2 = s2 / 32;
    m_r2 = s2 % 32;
    v = 4 * c1 + c2 - m_c2p;
    m_c2p = c2;
    if (v < 0) v = 0;
    if (v > 63) v = 63;
    return v;
  endfunction

  task automatic period(input int u, output int got);
    int exp, held;
    duty_in = 11'(u);
    upd = 1'b1;
    exp = model_step(u);
    @(negedge clk);
    upd = 1'b0;
    chk(duty_vld == 1'b1, "R7 vld after strobe", int'(duty_vld), 1);
    chk(int'(duty_out) == exp, "R2 R3 R4 R5 output", int'(duty_out), exp);
    got = int'(duty_out);
    held = got;
    duty_in = ~duty_in;
    @(negedge clk);
    chk(duty_vld == 1'b0, "R7 vld one clock", int'(duty_vld), 0);
    chk(int'(duty_out) == held, "R6 hold without strobe", int'(duty_out), held);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    upd = 1'b0;
    repeat (3) @(negedge clk);
    chk(duty_out == 6'd0, "R1 reset out", int'(duty_out), 0);
    chk(duty_vld == 1'b0, "R1 reset vld", int'(duty_vld), 0);
    m_r1 = 0; m_r2 = 0; m_c2p = 0;
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    int got, sum, cnt63;
    @(negedge clk);
    do_reset();

    period(200, got); chk(got == 6, "R1 R4 first period", got, 6);
    period(200, got); chk(got == 6, "R4 second period", got, 6);
    period(200, got); chk(got == 7, "R4 third period", got, 7);

    do_reset();
    period(200, got); chk(got == 6, "R1 cleared state", got, 6);

    for (int k = 0; k < 20; k++) period(0, got);
    chk(got == 0, "R5 zero input", got, 0);

    cnt63 = 0;
    for (int k = 0; k < 64; k++) begin
      period(2047, got);
      if (got == 63) cnt63++;
    end
    chk(cnt63 > 0, "R5 top clamp reached", cnt63, 1);

    for (int u = 0; u < 2048; u += 13) begin
      sum = 0;
      for (int k = 0; k < 128; k++) begin
        period(u, got);
        sum += got;
      end
      if (u >= 256 && u <= 1791) begin
        int diff;
        diff = sum * 32 - 128 * u;
        if (diff < 0) diff = -diff;
        chk(diff <= 128, "R8 long-run mean", sum * 32, 128 * u);
      end
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule